// File: doc/BRIEF.md
# Partitionable Associative Memory Array

This block is a small content-addressable memory of 16 entries, each 64 bits wide. A global split setting divides every entry into four 16-bit segments. The upper segments form the compared key and the lower segments carry associated data, which no compare ever looks at. Each entry also carries a two-bit type tag, and a compare only considers entries whose tag matches the selected type. A 64-bit mask can be switched in to drop single bit positions from every compare.

A compare strobe latches a match flag and the address of the lowest-addressed hit. The next free slot and a full flag are always available. Writes and reads can be aimed at four kinds of target: an absolute address, the latched match address, the next free slot, or an externally held address-register value. A read returns both the entry data and its tag.

Host bus framing, instruction decoding and the banked configuration registers sit outside this block. The block receives their decoded results as plain inputs.

Top module: `cam_array`

## Requirements
- R1: After reset every entry is tagged Empty (tag 2'b00) with data zero, match_o is 0, match_addr_o is 0, full_o is 0 and next_free_o is 0.
- R2: match_o and match_addr_o update one clock after cmp_req_i is sampled high, and hold their values while cmp_req_i is low. When nothing matches, match_addr_o is 0.
- R3: When several entries match, match_addr_o is the lowest matching address.
- R4: With split_i = k (0..3), the compare covers bits 63 down to 48-16k; bits below that never affect a compare.
- R5: When mask_en_i is 1, every bit set in mask_i is left out of the compare; when mask_en_i is 0, mask_i has no effect.
- R6: Tags are encoded Empty=2'b00, Valid=2'b01, Skip=2'b10, RAM=2'b11. With cmp_auto_i=1 only Valid entries take part; with cmp_auto_i=0 only entries whose tag equals cmp_tag_i take part.
- R7: wr_mode_i / rd_mode_i select the target: 2'b00 addr_i, 2'b01 the latched match address, 2'b10 the next free entry, 2'b11 areg_i. A write stores wr_data_i and wr_tag_i at the target on the next clock.
- R8: next_free_o is the lowest address tagged Empty; full_o is 1 exactly when no entry is tagged Empty.
- R9: A read updates rd_data_o and rd_tag_o one clock later with the data and tag of the target entry. A read whose target does not exist leaves both outputs unchanged.
- R10: A write in match mode while match_o is 0, or in next-free mode while full_o is 1, changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_i | input | 2 | Compared segment count minus one |
| mask_en_i | input | 1 | Apply mask_i during compares |
| mask_i | input | 64 | Bit positions to leave out of the compare |
| cmp_req_i | input | 1 | Compare strobe |
| cmp_auto_i | input | 1 | Restrict compare to Valid entries |
| cmp_tag_i | input | 2 | Tag type to compare when cmp_auto_i is 0 |
| comparand_i | input | 64 | Compare key |
| addr_i | input | 4 | Absolute address for reads and writes |
| areg_i | input | 4 | Address-register value |
| wr_en_i | input | 1 | Write request |
| wr_mode_i | input | 2 | Write target select |
| wr_data_i | input | 64 | Write data |
| wr_tag_i | input | 2 | Write tag |
| rd_en_i | input | 1 | Read request |
| rd_mode_i | input | 2 | Read target select |
| match_o | output | 1 | A compare hit |
| match_addr_o | output | 4 | Lowest hitting address |
| next_free_o | output | 4 | Lowest Empty address |
| full_o | output | 1 | No Empty entry |
| rd_data_o | output | 64 | Read data |
| rd_tag_o | output | 2 | Tag of the entry last read |

## Verification
The bench places two entries that share their top segment but differ below it. It then compares them at different splits and with the mask on and off. A wrong segment decode or an inverted mask would report the higher duplicate, or no hit at all. Entries with Skip, RAM and Empty tags are compared under automatic and explicit tag selection, so a block that ignores tags would hit on the Skip entry during an automatic compare. Match-mode writes are issued after a failed compare, and next-free writes and reads after the array fills. A design that does not gate these would corrupt entry 0 or return stale data as fresh.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef logic [1:0] tag_t;
  localparam tag_t TAG_EMPTY = 2'b00;
  localparam tag_t TAG_VALID = 2'b01;
  localparam tag_t TAG_SKIP  = 2'b10;
  localparam tag_t TAG_RAM   = 2'b11;

  typedef logic [1:0] amode_t;
  localparam amode_t AM_ABS   = 2'b00;
  localparam amode_t AM_MATCH = 2'b01;
  localparam amode_t AM_FREE  = 2'b10;
  localparam amode_t AM_AREG  = 2'b11;
endpackage

// File: rtl/cam_storage.sv
module cam_storage
  import cam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [WIDTH-1:0]            wdata_i,
  input  tag_t                        wtag_i,
  output logic [DEPTH-1:0][WIDTH-1:0] data_o,
  output logic [DEPTH-1:0][1:0]       tags_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[e] <= '0;
        tags_o[e] <= TAG_EMPTY;
      end else if (we_i && waddr_i == AW'(e)) begin
        data_o[e] <= wdata_i;
        tags_o[e] <= wtag_i;
      end
    end
  end
endmodule

// File: rtl/cam_cmp_mask.sv
module cam_cmp_mask #(
  parameter int WIDTH = 64,
  parameter int SEG_W = 16,
  localparam int NSEG = WIDTH / SEG_W,
  localparam int SPW  = $clog2(NSEG)
) (
  input  logic [SPW-1:0]   split_i,
  input  logic             mask_en_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] cmask_o
);
  // segment s is compared when it lies within the top split_i+1 segments
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int NEED = NSEG - 1 - s;
    logic seg_on;
    assign seg_on = (int'(split_i) >= NEED);
    assign cmask_o[s*SEG_W +: SEG_W] = {SEG_W{seg_on}}
                                     & ~(mask_en_i ? mask_i[s*SEG_W +: SEG_W] : '0);
  end
endmodule

// File: rtl/cam_match_vec.sv
module cam_match_vec
  import cam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] data_i,
  input  logic [DEPTH-1:0][1:0]       tags_i,
  input  logic [WIDTH-1:0]            key_i,
  input  logic [WIDTH-1:0]            cmask_i,
  input  tag_t                        sel_tag_i,
  output logic [DEPTH-1:0]            hit_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign hit_o[e] = (tags_i[e] == sel_tag_i)
                    && (((data_i[e] ^ key_i) & cmask_i) == '0);
  end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // descending scan: lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cam_array.sv
module cam_array
  import cam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  parameter int SEG_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NSEG = WIDTH / SEG_W,
  localparam int SPW  = $clog2(NSEG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SPW-1:0]   split_i,
  input  logic             mask_en_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             cmp_req_i,
  input  logic             cmp_auto_i,
  input  logic [1:0]       cmp_tag_i,
  input  logic [WIDTH-1:0] comparand_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [AW-1:0]    areg_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_mode_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [1:0]       wr_tag_i,
  input  logic             rd_en_i,
  input  logic [1:0]       rd_mode_i,
  output logic             match_o,
  output logic [AW-1:0]    match_addr_o,
  output logic [AW-1:0]    next_free_o,
  output logic             full_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [1:0]       rd_tag_o
);
  logic [DEPTH-1:0][WIDTH-1:0] data_vec;
  logic [DEPTH-1:0][1:0]       tag_vec;
  logic [WIDTH-1:0]            cmask;
  logic [DEPTH-1:0]            hit, empty_vec;
  logic                        hit_any, free_any;
  logic [AW-1:0]               hit_idx;
  tag_t                        sel_tag;
  logic                        we, wr_ok, rd_ok;
  logic [AW-1:0]               waddr, raddr;

  cam_cmp_mask #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_mask (
    .split_i  (split_i),
    .mask_en_i(mask_en_i),
    .mask_i   (mask_i),
    .cmask_o  (cmask)
  );

  assign sel_tag = cmp_auto_i ? TAG_VALID : cmp_tag_i;

  cam_match_vec #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match (
    .data_i   (data_vec),
    .tags_i   (tag_vec),
    .key_i    (comparand_i),
    .cmask_i  (cmask),
    .sel_tag_i(sel_tag),
    .hit_o    (hit)
  );

  cam_prio_enc #(.N(DEPTH)) u_hit_enc (
    .req_i(hit),
    .any_o(hit_any),
    .idx_o(hit_idx)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_empty
    assign empty_vec[e] = (tag_vec[e] == TAG_EMPTY);
  end

  cam_prio_enc #(.N(DEPTH)) u_free_enc (
    .req_i(empty_vec),
    .any_o(free_any),
    .idx_o(next_free_o)
  );

  assign full_o = ~free_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o      <= 1'b0;
      match_addr_o <= '0;
    end else if (cmp_req_i) begin
      match_o      <= hit_any;
      match_addr_o <= hit_idx;
    end
  end

  // target resolution shared by both access paths
  function automatic logic [AW:0] resolve(input amode_t m, input logic [AW-1:0] abs_a,
                                          input logic [AW-1:0] ar, input logic mv,
                                          input logic [AW-1:0] ma, input logic fv,
                                          input logic [AW-1:0] fa);
    unique case (m)
      AM_ABS:   return {1'b1, abs_a};
      AM_MATCH: return {mv, ma};
      AM_FREE:  return {fv, fa};
      default:  return {1'b1, ar};
    endcase
  endfunction

  assign {wr_ok, waddr} = resolve(wr_mode_i, addr_i, areg_i, match_o, match_addr_o,
                                  free_any, next_free_o);
  assign {rd_ok, raddr} = resolve(rd_mode_i, addr_i, areg_i, match_o, match_addr_o,
                                  free_any, next_free_o);
  assign we = wr_en_i && wr_ok;

  cam_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .wtag_i (wr_tag_i),
    .data_o (data_vec),
    .tags_o (tag_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      rd_tag_o  <= TAG_EMPTY;
    end else if (rd_en_i && rd_ok) begin
      rd_data_o <= data_vec[raddr];
      rd_tag_o  <= tag_vec[raddr];
    end
  end
endmodule

// File: rtl/cam_array_chk.sv
module cam_array_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmp_req_i,
  input logic                  match_o,
  input logic [AW-1:0]         match_addr_o,
  input logic                  wr_en_i,
  input logic [1:0]            wr_mode_i,
  input logic [1:0]            wr_tag_i,
  input logic                  rd_en_i,
  input logic [1:0]            rd_mode_i,
  input logic [AW-1:0]         addr_i,
  input logic                  full_o,
  input logic [AW-1:0]         next_free_o,
  input logic [1:0]            rd_tag_o,
  input logic [DEPTH-1:0][1:0] tags_i
);
  a_r2_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_req_i |=> $stable(match_o) && $stable(match_addr_o));

  a_r8_free_is_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |-> tags_i[next_free_o] == 2'b00);

  a_r8_free_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_mode_i == 2'b10 && !full_o && wr_tag_i != 2'b00
    |=> full_o || next_free_o != $past(next_free_o));

  a_r9_read_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_mode_i == 2'b00 && !wr_en_i |=> rd_tag_o == $past(tags_i[addr_i]));

  a_r10_no_match_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_mode_i == 2'b01 && !match_o |=> $stable(tags_i));

  a_r10_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_mode_i == 2'b10 && full_o |=> $stable(tags_i));
endmodule

bind cam_array cam_array_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmp_req_i   (cmp_req_i),
  .match_o     (match_o),
  .match_addr_o(match_addr_o),
  .wr_en_i     (wr_en_i),
  .wr_mode_i   (wr_mode_i),
  .wr_tag_i    (wr_tag_i),
  .rd_en_i     (rd_en_i),
  .rd_mode_i   (rd_mode_i),
  .addr_i      (addr_i),
  .full_o      (full_o),
  .next_free_o (next_free_o),
  .rd_tag_o    (rd_tag_o),
  .tags_i      (tag_vec)
);

// File: tb/tb_cam_array.sv
`timescale 1ns/1ps
module tb_cam_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  split = 2'd3;
  logic        mask_en = 1'b0;
  logic [63:0] mask = '0;
  logic        cmp_req = 1'b0, cmp_auto = 1'b0;
  logic [1:0]  cmp_tag = 2'b00;
  logic [63:0] key = '0;
  logic [3:0]  addr = '0, areg = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_mode = '0, rd_mode = '0, wr_tag = '0;
  logic [63:0] wr_data = '0;
  logic        match, full;
  logic [3:0]  match_addr, next_free;
  logic [63:0] rd_data;
  logic [1:0]  rd_tag;

  always #2 clk = ~clk;

  cam_array dut (
    .clk_i(clk), .rst_ni(rst_n), .split_i(split), .mask_en_i(mask_en), .mask_i(mask),
    .cmp_req_i(cmp_req), .cmp_auto_i(cmp_auto), .cmp_tag_i(cmp_tag), .comparand_i(key),
    .addr_i(addr), .areg_i(areg), .wr_en_i(wr_en), .wr_mode_i(wr_mode),
    .wr_data_i(wr_data), .wr_tag_i(wr_tag), .rd_en_i(rd_en), .rd_mode_i(rd_mode),
    .match_o(match), .match_addr_o(match_addr), .next_free_o(next_free), .full_o(full),
    .rd_data_o(rd_data), .rd_tag_o(rd_tag)
  );

  // reference model
  logic [63:0] m_data [16];
  logic [1:0]  m_tag  [16];
  logic        m_match = 1'b0;
  logic [3:0]  m_maddr = '0;
  logic [63:0] m_rdata = '0;
  logic [1:0]  m_rtag = '0;

  typedef struct {
    int          kind;   // 0 compare, 1 read, 2 flags
    string       req;
    logic [63:0] d;
    logic [3:0]  a;
    logic        b;
    logic [1:0]  t;
  } item_t;
  item_t sb[$];

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic m_full();
    for (int e = 0; e < 16; e++) if (m_tag[e] == 2'b00) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [3:0] m_free();
    for (int e = 0; e < 16; e++) if (m_tag[e] == 2'b00) return 4'(e);
    return 4'd0;
  endfunction

  // returns {ok, addr}
  function automatic logic [4:0] m_target(input logic [1:0] md, input logic [3:0] a);
    case (md)
      2'b00:   return {1'b1, a};
      2'b01:   return {m_match, m_maddr};
      2'b10:   return {~m_full(), m_free()};
      default: return {1'b1, areg};
    endcase
  endfunction

  task automatic idle();
    cmp_req = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] md, input logic [3:0] a,
                          input logic [63:0] d, input logic [1:0] t);
    logic [4:0] tg;
    @(negedge clk); idle();
    wr_en = 1'b1; wr_mode = md; addr = a; wr_data = d; wr_tag = t;
    tg = m_target(md, a);
    if (tg[4]) begin m_data[tg[3:0]] = d; m_tag[tg[3:0]] = t; end
  endtask

  task automatic do_read(input logic [1:0] md, input logic [3:0] a, input string r);
    logic [4:0] tg;
    item_t it;
    @(negedge clk); idle();
    rd_en = 1'b1; rd_mode = md; addr = a;
    tg = m_target(md, a);
    if (tg[4]) begin m_rdata = m_data[tg[3:0]]; m_rtag = m_tag[tg[3:0]]; end
    it.kind = 1; it.req = r; it.d = m_rdata; it.t = m_rtag; it.a = '0; it.b = 1'b0;
    sb.push_back(it);
  endtask

  task automatic do_cmp(input logic au, input logic [1:0] t, input logic [63:0] k,
                        input logic [1:0] sp, input logic me, input logic [63:0] mk,
                        input string r);
    item_t it;
    logic [1:0] sel;
    @(negedge clk); idle();
    cmp_req = 1'b1; cmp_auto = au; cmp_tag = t; key = k; split = sp; mask_en = me; mask = mk;
    sel = au ? 2'b01 : t;
    m_match = 1'b0; m_maddr = '0;
    for (int e = 15; e >= 0; e--) begin
      logic hit;
      hit = (m_tag[e] == sel);
      for (int b = 0; b < 64; b++)
        if (b >= 48 - 16 * int'(sp) && !(me && mk[b]) && m_data[e][b] != k[b]) hit = 1'b0;
      if (hit) begin m_match = 1'b1; m_maddr = 4'(e); end
    end
    it.kind = 0; it.req = r; it.b = m_match; it.a = m_maddr; it.d = '0; it.t = '0;
    sb.push_back(it);
  endtask

  task automatic chk_flags(input string r);
    item_t it;
    @(negedge clk); idle();
    key = ~key; // compare result must not follow the comparand without a strobe
    it.kind = 2; it.req = r; it.b = m_full(); it.a = m_free(); it.t = {m_match, 1'b0};
    it.d = {60'd0, m_maddr};
    sb.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      case (it.kind)
        0: if (match !== it.b || match_addr !== it.a) begin
             errors++;
             $display("FAIL %s: match=%0b addr=%0d expected match=%0b addr=%0d",
                      it.req, match, match_addr, it.b, it.a);
           end
        1: if (rd_data !== it.d || rd_tag !== it.t) begin
             errors++;
             $display("FAIL %s: data=%h tag=%0d expected data=%h tag=%0d",
                      it.req, rd_data, rd_tag, it.d, it.t);
           end
        default: if (full !== it.b || next_free !== it.a || match !== it.t[1]
                     || match_addr !== it.d[3:0]) begin
             errors++;
             $display("FAIL %s: full=%0b free=%0d match=%0b maddr=%0d expected %0b %0d %0b %0d",
                      it.req, full, next_free, match, match_addr,
                      it.b, it.a, it.t[1], it.d[3:0]);
           end
      endcase
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 16; e++) begin m_data[e] = '0; m_tag[e] = 2'b00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_flags("R1 reset state");
    do_read(2'b00, 4'd7, "R1 reset entry empty");

    // populate via next-free (R7, R8)
    do_write(2'b10, 0, 64'h1000_0000_0000_0000, 2'b01);
    chk_flags("R8 next free after one write");
    do_write(2'b10, 0, 64'hAAAA_1111_2222_3333, 2'b01);
    do_write(2'b10, 0, 64'h5555_0000_0000_00FF, 2'b10);
    do_write(2'b10, 0, 64'h0123_4567_89AB_CDEF, 2'b01);
    do_write(2'b10, 0, 64'hAAAA_9999_8888_7777, 2'b01);
    do_write(2'b10, 0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11);
    chk_flags("R8 next free after six writes");
    do_read(2'b00, 4'd4, "R7 next-free write landed at 4");

    do_cmp(1, 2'b00, 64'h0123_4567_89AB_CDEF, 2'd3, 0, '0, "R2 exact hit");
    chk_flags("R2 result held with new comparand");
    do_read(2'b01, 0, "R9 read at match address");
    do_cmp(1, 2'b00, 64'hAAAA_9999_8888_7777, 2'd0, 0, '0, "R3 R4 one segment lowest wins");
    do_cmp(1, 2'b00, 64'hAAAA_9999_8888_7777, 2'd3, 0, '0, "R4 full width picks 4");
    do_cmp(1, 2'b00, 64'hAAAA_1111_0000_0000, 2'd1, 0, '0, "R4 two segments");
    do_cmp(1, 2'b00, 64'hAAAA_1111_0000_0000, 2'd2, 0, '0, "R4 three segments miss");
    do_cmp(1, 2'b00, 64'hAAAA_0000_0000_0000, 2'd3, 1, 64'h0000_FFFF_FFFF_FFFF, "R5 mask on");
    do_cmp(1, 2'b00, 64'hAAAA_0000_0000_0000, 2'd3, 0, 64'h0000_FFFF_FFFF_FFFF, "R5 mask off");
    do_cmp(1, 2'b00, 64'h5555_0000_0000_00FF, 2'd3, 0, '0, "R6 auto skips Skip");
    do_cmp(0, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, '0, "R6 RAM tag");
    do_cmp(0, 2'b00, 64'h0, 2'd3, 0, '0, "R6 Empty tag");
    do_cmp(0, 2'b10, 64'h5555_0000_0000_00FF, 2'd3, 0, '0, "R6 Skip tag");

    do_write(2'b01, 0, 64'h2222_2222_2222_2222, 2'b01);
    do_read(2'b00, 4'd2, "R7 match-mode write");
    do_cmp(1, 2'b00, 64'hDEAD_BEEF_0000_0000, 2'd3, 0, '0, "R2 miss gives addr 0");
    do_write(2'b01, 0, 64'h3333_3333_3333_3333, 2'b11);
    do_read(2'b00, 4'd0, "R10 match-mode write with no match");
    do_read(2'b01, 0, "R9 match-mode read with no match unchanged");

    areg = 4'd10;
    do_write(2'b11, 0, 64'hA5A5_A5A5_0000_1111, 2'b01);
    do_read(2'b11, 0, "R7 address-register write and read");
    do_write(2'b00, 4'd12, 64'h0C0C_0C0C_0C0C_0C0C, 2'b10);
    do_read(2'b00, 4'd12, "R7 absolute write");
    chk_flags("R8 free skips over filled slots");

    while (!m_full()) do_write(2'b10, 0, 64'h7700_0000_0000_0000 | 64'(m_free()), 2'b01);
    chk_flags("R8 full after fill");
    do_write(2'b10, 0, 64'h9999_9999_9999_9999, 2'b00);
    chk_flags("R10 next-free write when full");
    do_read(2'b00, 4'd15, "R10 last entry intact");
    do_read(2'b10, 0, "R9 next-free read when full unchanged");
    do_cmp(1, 2'b00, 64'h7700_0000_0000_0000, 2'd0, 0, '0, "R3 many hits lowest wins");

    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule